// File: doc/BRIEF.md
# Security-Gated Peripheral Reset Control Register

This block is a single memory-mapped control word whose five low bits each hold one peripheral in reset: an advanced timer, a SPI controller, a UART, and two general-purpose timers. Software sets a bit to hold that peripheral in reset. The reset stays asserted until software clears the bit again. Each stored bit drives a level reset output through its flop, so the output follows the stored bit with no extra delay.

Every bit carries its own security attribute, supplied by an external configuration block. A non-secure master cannot see or change a bit that is marked secure. Two separate enables add privilege protection: one for secure bits and one for non-secure bits. When a protection applies, an unprivileged master also cannot see or change the bit. An access that is blocked does not fail. The blocked bits read as zero and keep their value, while the permitted bits in the same word are read or written as usual. The bus port is a plain single-cycle interface. Writes commit on the clock edge of the access, and read data is combinational.

Top module: `periph_rst_ctrl`

## Requirements
- R1: Reset (rst_n low) clears all five bits, so every reset output and every readable bit is 0.
- R2: A permitted write of 1 to a bit raises its reset output from the next clock edge. The output then stays high, with no self-clearing, until a permitted write of 0 to that bit. With no write to the register address, the outputs do not change.
- R3: Bit mapping in the data word and on periph_rst_o: bit 0 is the advanced timer, bit 1 is SPI, bit 2 is the UART, bit 3 is general timer A and bit 4 is general timer B. Data bits 5 and above always read as 0, and writing them has no effect.
- R4: When bit_secure[i] is 1 and mst_secure is 0, bit i reads as 0 and a write leaves it unchanged.
- R5: When bit_secure[i] is 1, sec_priv_en is 1 and mst_priv is 0, bit i reads as 0 and a write leaves it unchanged.
- R6: When bit_secure[i] is 0, nsec_priv_en is 1 and mst_priv is 0, bit i reads as 0 and a write leaves it unchanged. sec_priv_en has no effect on non-secure bits.
- R7: Masking is decided bit by bit. In one write, the permitted bits take the write data and the blocked bits keep their old value.
- R8: bus_rdata is 0 unless bus_re is high and bus_addr equals REG_ADDR. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, committed at the clock edge |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, masked per bit |
| mst_secure | input | 1 | Master is secure |
| mst_priv | input | 1 | Master is privileged |
| bit_secure | input | N_PERIPH | Per-bit security attribute |
| sec_priv_en | input | 1 | Privilege protection for secure bits |
| nsec_priv_en | input | 1 | Privilege protection for non-secure bits |
| periph_rst_o | output | N_PERIPH | Level reset to each peripheral |

## Verification
The bound checker checks the following on every cycle:
- The outputs stay unchanged when no write reaches the register.
- Secure bits survive any non-secure write.
- Reads never expose a bit that security or privilege masking hides.
- The upper data bits and idle reads return zero.

The bench scenarios show what a property cannot show alone:
- A mixed write updates exactly the permitted bits, by walking a table of attribute combinations and checking the stored state afterwards.
- A set bit keeps its reset held across idle cycles.
- A reset in the middle of operation clears the stored state.

// File: rtl/periph_rst_ctrl.sv
module periph_rst_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int N_PERIPH = 5,
  parameter int REG_ADDR = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                mst_secure,
  input  logic                mst_priv,
  input  logic [N_PERIPH-1:0] bit_secure,
  input  logic                sec_priv_en,
  input  logic                nsec_priv_en,
  output logic [N_PERIPH-1:0] periph_rst_o
);
  localparam int PAD_W = DATA_W - N_PERIPH;

  logic [N_PERIPH-1:0] ctl_q;
  logic [N_PERIPH-1:0] access_ok;
  logic                hit;

  assign hit = (bus_addr == ADDR_W'(REG_ADDR));

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_gate
    logic need_priv;
    assign need_priv    = bit_secure[i] ? sec_priv_en : nsec_priv_en;
    assign access_ok[i] = (mst_secure | ~bit_secure[i]) & (mst_priv | ~need_priv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (bus_we && hit)
      ctl_q <= (bus_wdata[N_PERIPH-1:0] & access_ok) | (ctl_q & ~access_ok);
  end

  assign bus_rdata    = (bus_re && hit) ? {{PAD_W{1'b0}}, ctl_q & access_ok} : '0;
  assign periph_rst_o = ctl_q;

  wire unused_wdata_hi = ^bus_wdata[DATA_W-1:N_PERIPH];
endmodule

// File: rtl/periph_rst_ctrl_chk.sv
module periph_rst_ctrl_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int N_PERIPH = 5,
  parameter int REG_ADDR = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic                bus_re,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                mst_secure,
  input logic                mst_priv,
  input logic [N_PERIPH-1:0] bit_secure,
  input logic                sec_priv_en,
  input logic                nsec_priv_en,
  input logic [N_PERIPH-1:0] periph_rst_o
);
  logic at_reg;
  assign at_reg = (bus_addr == ADDR_W'(REG_ADDR));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && at_reg) |=> $stable(periph_rst_o));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:N_PERIPH] == '0);

  assert_sec_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && at_reg && !mst_secure) |=>
      ((periph_rst_o ^ $past(periph_rst_o)) & $past(bit_secure)) == '0);

  assert_sec_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !mst_secure) |-> (bus_rdata[N_PERIPH-1:0] & bit_secure) == '0);

  assert_spriv_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !mst_priv && sec_priv_en) |-> (bus_rdata[N_PERIPH-1:0] & bit_secure) == '0);

  assert_nspriv_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !mst_priv && nsec_priv_en) |-> (bus_rdata[N_PERIPH-1:0] & ~bit_secure) == '0);

  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && at_reg) |-> bus_rdata == '0);
endmodule

bind periph_rst_ctrl periph_rst_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PERIPH(N_PERIPH), .REG_ADDR(REG_ADDR)
) chk_i (.*);

// File: tb/periph_rst_ctrl_tb_top.sv
module periph_rst_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mst_secure = 1'b1, mst_priv = 1'b1;
  logic [4:0]  bit_secure = '0;
  logic        sec_priv_en = 1'b0, nsec_priv_en = 1'b0;
  logic [4:0]  periph_rst_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  periph_rst_ctrl dut_i (.*);

  // {sec, priv, bit_secure[4:0], sec_priv_en, nsec_priv_en, wdata[7:0], expected[4:0]}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b1, 5'b00000, 1'b0, 1'b0, 8'h1F, 5'h1F},  // R2 all set
    {1'b0, 1'b1, 5'b00101, 1'b0, 1'b0, 8'h00, 5'h05},  // R4 R7
    {1'b0, 1'b1, 5'b00101, 1'b0, 1'b0, 8'hFA, 5'h1F},  // R3 R7
    {1'b1, 1'b0, 5'b00011, 1'b1, 1'b0, 8'h00, 5'h03},  // R5
    {1'b1, 1'b0, 5'b00011, 1'b0, 1'b1, 8'h1C, 5'h00},  // R6
    {1'b0, 1'b0, 5'b00000, 1'b1, 1'b0, 8'h1F, 5'h1F},  // R6
    {1'b1, 1'b1, 5'b11111, 1'b1, 1'b1, 8'h08, 5'h08},  // R2
    {1'b0, 1'b1, 5'b11111, 1'b0, 1'b0, 8'h17, 5'h08},  // R4
    {1'b1, 1'b1, 5'b00000, 1'b0, 1'b0, 8'h10, 5'h10},  // R3
    {1'b1, 1'b1, 5'b00000, 1'b0, 1'b0, 8'h01, 5'h01}   // R3
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic attr(logic s, logic p, logic [4:0] bs, logic spe, logic npe);
    mst_secure = s; mst_priv = p; bit_secure = bs;
    sec_priv_en = spe; nsec_priv_en = npe;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'b0, periph_rst_o}, 32'h0);
    rst_n = 1'b1;
    rd(4'h0, d);
    chk("R1 reset read", d, 32'h0);

    for (int k = 0; k < NV; k++) begin
      attr(VEC[k][21], VEC[k][20], VEC[k][19:15], VEC[k][14], VEC[k][13]);
      wr(4'h0, {24'h0, VEC[k][12:5]});
      chk("R2 R7 vector outputs", {27'b0, periph_rst_o}, {27'b0, VEC[k][4:0]});
      attr(1'b1, 1'b1, 5'b00000, 1'b0, 1'b0);
      rd(4'h0, d);
      chk("R3 R7 vector readback", d, {27'b0, VEC[k][4:0]});
    end

    attr(1'b1, 1'b1, 5'b00000, 1'b0, 1'b0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d);
    chk("R3 upper bits read zero", d, 32'h1F);

    attr(1'b0, 1'b1, 5'b00110, 1'b0, 1'b0);
    rd(4'h0, d);
    chk("R4 non-secure read of secure bits", d, 32'h19);

    attr(1'b1, 1'b0, 5'b00011, 1'b1, 1'b0);
    rd(4'h0, d);
    chk("R5 unprivileged read of secure bits", d, 32'h1C);

    attr(1'b1, 1'b0, 5'b00000, 1'b0, 1'b1);
    rd(4'h0, d);
    chk("R6 unprivileged read of non-secure bits", d, 32'h00);

    attr(1'b1, 1'b0, 5'b11000, 1'b0, 1'b1);
    rd(4'h0, d);
    chk("R6 mixed attribute read", d, 32'h18);

    attr(1'b1, 1'b1, 5'b00000, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 idle read", bus_rdata, 32'h0);
    rd(4'h3, d);
    chk("R8 other address read", d, 32'h0);
    wr(4'h3, 32'h0);
    chk("R8 other address write", {27'b0, periph_rst_o}, 32'h1F);

    repeat (20) @(negedge clk);
    chk("R2 no self clear", {27'b0, periph_rst_o}, 32'h1F);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", {27'b0, periph_rst_o}, 32'h0);
    rst_n = 1'b1;
    rd(4'h0, d);
    chk("R1 read after reset", d, 32'h0);

    finish_run();
  end
endmodule